// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs clause-22 management transactions towards an external PHY. Software first sets an enable bit in a control register, then writes one 32-bit command word carrying the operation, the PHY address, the register address and, for writes, sixteen data bits. The engine turns that word into a complete 64-bit serial frame on the MDC clock and the bidirectional MDIO data line. While the frame is on the wire, an idle flag in a status register reads zero.

For a read, the controller releases the data line for the turnaround and data phases. It shifts in the sixteen bits the PHY returns and writes them into the low half of the command register, where software collects them once the idle flag is back. An undriven line is pulled high, so an absent PHY reads as all ones. Software can therefore probe addresses from the top down until a real answer appears.

MDC runs at the system clock divided by 48 or by 64, chosen by a select input. The select is latched when a command is accepted. Commands that arrive while a frame is running, or while the port is disabled, are dropped.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset the status register reads idle (bit 2 = 1), MDC is low, the output enable is low, and both the control and command registers read zero.
- R2: Register map on `regAddr`: 0 is control (bit 0 = port enable), 1 is status (bit 2 = idle), 2 is command, and 3 reads zero. A command write is accepted when the port is enabled and idle. An accepted write stores the word and starts a frame.
- R3: The frame is 64 bits, sent MSB first: 32 ones, start `01`, opcode `10` when command bit 29 is set and `01` otherwise, PHY address from command bits 27:23, register address from bits 22:18, then turnaround and 16 data bits. A write frame uses turnaround `10` and data from command bits 15:0.
- R4: A write frame drives the line (output enable high) for all 64 bits. A read frame drives bits 0 to 45 and releases the line from the first turnaround bit (bit 46) through the last data bit.
- R5: MDC is low when idle. During a frame it has a period of 48 system clocks when `divSel` is 0 and 64 when it is 1, and it is high for half of each period. The output changes only while MDC is low; input is sampled at the rising edge.
- R6: At the end of a read frame, command bits 15:0 hold the 16 bits sampled during the data phase, MSB first. Command bits 31:16 keep the value that was written.
- R7: When no PHY drives the line during a read, the pulled-up line makes the returned data 0xFFFF, so a downward address scan reads all ones until it reaches the responding address.
- R8: A command write during a frame is ignored. The frame on the wire and the command register are unchanged by it.
- R9: While the port enable is clear, a command write is ignored. MDC stays low, no frame is sent and the command register keeps its value.
- R10: The idle bit reads 0 from the cycle after an accepted write until the frame ends. When it reads 1 again, the command register already holds any read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for both write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| divSel | input | 1 | MDC ratio select: 0 = divide by 48, 1 = divide by 64 |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Serial data driven onto the line |
| mdioOe | output | 1 | Output enable for the line driver |
| mdioIn | input | 1 | Level seen on the line |

## Verification
The assertions take for granted that `mdioIn` is only consulted while the controller has released the line. They also assume that register writes arrive one per cycle through the single port, so enabling the port and issuing a command never coincide. The bench keeps within this: its PHY model drives the line only in the turnaround and data phases of a read addressed to it, and otherwise leaves a pull-up value. Register accesses are issued on falling clock edges, one at a time. Commands that land mid-frame or while the port is disabled are issued on purpose, to exercise the rules that drop them.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int DATA_W     = 16;
  localparam int TA_FIRST   = FRAME_BITS - DATA_W - 2;
  localparam int DATA_FIRST = FRAME_BITS - DATA_W;

  // command word fields
  localparam int RD_BIT  = 29;
  localparam int PHY_LSB = 23;
  localparam int REG_LSB = 18;
  localparam int ADR_W   = 5;

  // register map
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CMD  = 2'd2;
  localparam int STAT_IDLE_BIT = 2;

  typedef struct packed {
    logic             rise;    // MDC goes high at this edge: sample input
    logic             fall;    // MDC goes low and the next bit starts
    logic             finish;  // last bit period ends
    logic [IDX_W-1:0] bitIdx;  // bit currently on the wire
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_frame_timer.sv
module mdio_frame_timer
  import mdio_frame_pkg::*;
#(
  parameter int DIV_SEL0 = 48,
  parameter int DIV_SEL1 = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        divSel,
  output logic        busy,
  output logic        mdc,
  output mdioStrobe_t strb
);
  localparam int DIV_MAX = (DIV_SEL0 > DIV_SEL1) ? DIV_SEL0 : DIV_SEL1;
  localparam int CW = $clog2(DIV_MAX);
  localparam logic [CW-1:0] END0  = CW'(DIV_SEL0 - 1);
  localparam logic [CW-1:0] END1  = CW'(DIV_SEL1 - 1);
  localparam logic [CW-1:0] HALF0 = CW'(DIV_SEL0 / 2 - 1);
  localparam logic [CW-1:0] HALF1 = CW'(DIV_SEL1 / 2 - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic             selQ;
  logic             busyQ;
  logic             mdcQ;
  logic [CW-1:0]    divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [CW-1:0]    periodEnd;
  logic [CW-1:0]    halfEnd;

  assign periodEnd = selQ ? END1 : END0;
  assign halfEnd   = selQ ? HALF1 : HALF0;

  always_comb begin
    strb.rise   = busyQ && (divCnt == halfEnd);
    strb.fall   = busyQ && (divCnt == periodEnd) && (bitIdx != LAST_IDX);
    strb.finish = busyQ && (divCnt == periodEnd) && (bitIdx == LAST_IDX);
    strb.bitIdx = bitIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= 1'b0;
      busyQ  <= 1'b0;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (start) begin
      selQ   <= divSel;
      busyQ  <= 1'b1;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busyQ) begin
      if (divCnt == periodEnd) begin
        mdcQ   <= 1'b0;
        divCnt <= '0;
        if (bitIdx == LAST_IDX) busyQ <= 1'b0;
        else                    bitIdx <= bitIdx + IDX_W'(1);
      end else begin
        if (divCnt == halfEnd) mdcQ <= 1'b1;
        divCnt <= divCnt + CW'(1);
      end
    end
  end

  assign busy = busyQ;
  assign mdc  = mdcQ;
endmodule

// File: rtl/mdio_frame_datapath.sv
module mdio_frame_datapath
  import mdio_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] wrWord,
  input  mdioStrobe_t strb,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic [31:0] cmdWord
);
  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] frameWord;
  logic [DATA_W-1:0]     rxShift;
  logic                  oeQ;
  logic [31:0]           cmdQ;
  logic                  newRd;
  logic                  curRd;
  logic [IDX_W-1:0]      nextIdx;

  assign newRd   = wrWord[RD_BIT];
  assign curRd   = cmdQ[RD_BIT];
  assign nextIdx = strb.bitIdx + IDX_W'(1);

  always_comb begin
    frameWord = {{PRE_BITS{1'b1}}, 2'b01,
                 newRd ? 2'b10 : 2'b01,
                 wrWord[PHY_LSB +: ADR_W],
                 wrWord[REG_LSB +: ADR_W],
                 newRd ? 2'b11 : 2'b10,
                 newRd ? {DATA_W{1'b1}} : wrWord[DATA_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      oeQ     <= 1'b0;
      cmdQ    <= '0;
    end else if (start) begin
      txShift <= frameWord;
      oeQ     <= 1'b1;
      cmdQ    <= wrWord;
    end else begin
      if (strb.fall) begin
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
        oeQ     <= !(curRd && (nextIdx >= IDX_W'(TA_FIRST)));
      end
      if (strb.rise && curRd && (strb.bitIdx >= IDX_W'(DATA_FIRST)))
        rxShift <= {rxShift[DATA_W-2:0], mdioIn};
      if (strb.finish) begin
        oeQ <= 1'b0;
        if (curRd) cmdQ[DATA_W-1:0] <= rxShift;
      end
    end
  end

  assign mdioOut = txShift[FRAME_BITS-1];
  assign mdioOe  = oeQ;
  assign cmdWord = cmdQ;
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_frame_pkg::*;
#(
  parameter int DIV_SEL0 = 48,
  parameter int DIV_SEL1 = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        divSel,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  logic        portEn;
  logic        busy;
  logic        start;
  logic [31:0] cmdWord;
  mdioStrobe_t strb;

  assign start = regWrEn && (regAddr == REG_CMD) && portEn && !busy;

  always_ff @(posedge clk) begin
    if (!rstN)                                  portEn <= 1'b0;
    else if (regWrEn && (regAddr == REG_CTRL))  portEn <= regWrData[0];
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL: regRdData[0] = portEn;
      REG_STAT: regRdData[STAT_IDLE_BIT] = !busy;
      REG_CMD:  regRdData = cmdWord;
      default:  regRdData = '0;
    endcase
  end

  mdio_frame_timer #(.DIV_SEL0(DIV_SEL0), .DIV_SEL1(DIV_SEL1)) u_timer (
    .clk(clk), .rstN(rstN), .start(start), .divSel(divSel),
    .busy(busy), .mdc(mdc), .strb(strb)
  );

  mdio_frame_datapath u_dp (
    .clk(clk), .rstN(rstN), .start(start), .wrWord(regWrData),
    .strb(strb), .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .cmdWord(cmdWord)
  );
endmodule

// File: rtl/mdio_frame_chk.sv
module mdio_frame_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        busy,
  input logic        portEn,
  input logic [31:0] cmdWord
);
  // R1 and R5: nothing toggles or drives while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  // R5: output and enable hold while MDC is high
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> ($stable(mdioOut) && $stable(mdioOe)));

  // R8: command register untouched during a running frame
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cmdWord));

  // R9: a disabled idle port does not start
  p_no_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!portEn && !busy) |=> !busy);

  // R4: the line is released mid-frame only by a read
  p_release_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $fell(mdioOe)) |-> cmdWord[29]);
endmodule

bind mdio_frame_ctrl mdio_frame_chk u_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .busy(busy), .portEn(portEn), .cmdWord(cmdWord)
);

// File: tb/test_mdio_frame_ctrl.sv
module test_mdio_frame_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        divSel = 1'b0;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int nChecks = 0;
  int nFails  = 0;

  // PHY model state
  int          phyBitCnt = 0;
  logic [63:0] seenOut = '0;
  logic [63:0] seenOe  = '0;
  logic        phyAns = 1'b0;
  logic        phyDrv = 1'b0;
  logic        phyVal = 1'b1;
  logic        phyPresent = 1'b0;
  logic [4:0]  phyAddrModel = 5'd0;
  logic [15:0] phyData = '0;

  // MDC timing monitor
  int cyc = 0;
  int lastRise = -1;
  int perMin, perMax, hiMin, hiMax;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  assign mdioIn = phyDrv ? phyVal : 1'b1;

  mdio_frame_ctrl i_mdio_frame_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .divSel(divSel),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge mdc) begin
    seenOut = {seenOut[62:0], mdioOut};
    seenOe  = {seenOe[62:0], mdioOe};
    phyBitCnt++;
    if (lastRise >= 0) begin
      if (cyc - lastRise < perMin) perMin = cyc - lastRise;
      if (cyc - lastRise > perMax) perMax = cyc - lastRise;
    end
    lastRise = cyc;
  end

  always @(negedge mdc) begin
    if (cyc - lastRise < hiMin) hiMin = cyc - lastRise;
    if (cyc - lastRise > hiMax) hiMax = cyc - lastRise;
    if (phyBitCnt == 46)
      phyAns = (seenOut[11:10] == 2'b10) && phyPresent && (seenOut[9:5] == phyAddrModel);
    if (phyAns && phyBitCnt >= 47 && phyBitCnt <= 63) begin
      phyDrv = 1'b1;
      phyVal = (phyBitCnt == 47) ? 1'b0 : phyData[63 - phyBitCnt];
    end else begin
      phyDrv = 1'b0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  function automatic logic [31:0] mkCmd(input bit rd, input logic [4:0] phy,
                                        input logic [4:0] rg, input logic [15:0] d);
    return (32'h1 << 30) | (rd ? (32'h1 << 29) : (32'h1 << 28)) |
           (32'(phy) << 23) | (32'(rg) << 18) | (32'h1 << 17) | 32'(d);
  endfunction

  function automatic logic [63:0] expFrame(input logic [31:0] c);
    logic rd;
    rd = c[29];
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, c[27:23], c[22:18],
            rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : c[15:0]};
  endfunction

  task automatic armMonitor();
    phyBitCnt = 0; seenOut = '0; seenOe = '0; phyAns = 1'b0; phyDrv = 1'b0;
    lastRise = -1; perMin = 1 << 20; perMax = 0; hiMin = 1 << 20; hiMax = 0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 9000; i++) begin
      rdReg(mdio_frame_pkg::REG_STAT, v);
      if (v[2]) break;
    end
  endtask

  // Run one accepted frame and check wire contents, timing and result
  task automatic runFrame(input logic [31:0] c, input bit sel, input logic [15:0] expRd);
    logic [31:0] v;
    logic [63:0] ef, eo;
    int div;
    div = sel ? 64 : 48;
    divSel = sel;
    armMonitor();
    wrReg(mdio_frame_pkg::REG_CMD, c);
    rdReg(mdio_frame_pkg::REG_STAT, v);
    chk(v[2] == 1'b0, "R10 busy after accept", 64'(v), 64'h0);
    waitIdle();
    ef = expFrame(c);
    eo = c[29] ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    chk(phyBitCnt == 64, "R3 bit count", 64'(phyBitCnt), 64'd64);
    if (c[29]) chk(seenOut[63:18] == ef[63:18], "R3 read frame", seenOut, ef);
    else       chk(seenOut == ef, "R3 write frame", seenOut, ef);
    chk(seenOe == eo, "R4 output enable", seenOe, eo);
    chk(perMin == div && perMax == div, "R5 MDC period", 64'(perMax), 64'(div));
    chk(hiMin == div/2 && hiMax == div/2, "R5 MDC high time", 64'(hiMin), 64'(div/2));
    chk(mdc == 1'b0 && mdioOe == 1'b0, "R5 idle pins", {mdc, mdioOe}, 2'b00);
    rdReg(mdio_frame_pkg::REG_CMD, v);
    if (c[29]) chk(v == {c[31:16], expRd}, "R6 read result", v, {c[31:16], expRd});
    else       chk(v == c, "R6 write keeps command", v, c);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, cA, cB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdReg(mdio_frame_pkg::REG_STAT, v);
    chk(v == 32'h4, "R1 status idle", v, 32'h4);
    rdReg(mdio_frame_pkg::REG_CTRL, v);
    chk(v == 32'h0, "R1 control zero", v, 32'h0);
    rdReg(mdio_frame_pkg::REG_CMD, v);
    chk(v == 32'h0, "R1 command zero", v, 32'h0);
    chk(mdc == 1'b0 && mdioOe == 1'b0, "R1 pins quiet", {mdc, mdioOe}, 2'b00);
    rdReg(2'd3, v);
    chk(v == 32'h0, "R2 unused address", v, 32'h0);

    // R9 disabled port drops commands
    armMonitor();
    wrReg(mdio_frame_pkg::REG_CMD, mkCmd(1'b0, 5'd1, 5'd2, 16'h1111));
    repeat (200) @(negedge clk);
    chk(phyBitCnt == 0, "R9 no MDC activity", 64'(phyBitCnt), 64'd0);
    rdReg(mdio_frame_pkg::REG_STAT, v);
    chk(v[2] == 1'b1, "R9 stays idle", 64'(v), 64'h4);
    rdReg(mdio_frame_pkg::REG_CMD, v);
    chk(v == 32'h0, "R9 command unchanged", v, 32'h0);

    wrReg(mdio_frame_pkg::REG_CTRL, 32'h1);
    rdReg(mdio_frame_pkg::REG_CTRL, v);
    chk(v == 32'h1, "R2 enable readback", v, 32'h1);

    // R3/R4/R5 write frames over several field patterns
    runFrame(mkCmd(1'b0, 5'd0,  5'd0,  16'h0000), 1'b0, 16'h0);
    runFrame(mkCmd(1'b0, 5'd31, 5'd31, 16'hFFFF), 1'b0, 16'h0);
    runFrame(mkCmd(1'b0, 5'd5,  5'd9,  16'hA55A), 1'b0, 16'h0);
    runFrame(mkCmd(1'b0, 5'd18, 5'd3,  16'h1234), 1'b0, 16'h0);
    runFrame(mkCmd(1'b0, 5'd12, 5'd7,  16'h0F0F), 1'b1, 16'h0);

    // R6 read from a present PHY; R7 read from an absent one
    phyPresent = 1'b1; phyAddrModel = 5'd9; phyData = 16'hC3A5;
    runFrame(mkCmd(1'b1, 5'd9,  5'd2, 16'h0000), 1'b0, 16'hC3A5);
    runFrame(mkCmd(1'b1, 5'd10, 5'd2, 16'h0000), 1'b0, 16'hFFFF);

    // R7 downward address scan
    phyAddrModel = 5'd28; phyData = 16'h796D;
    for (int a = 31; a >= 28; a--)
      runFrame(mkCmd(1'b1, 5'(a), 5'd1, 16'h0000), 1'b0,
               (a == 28) ? 16'h796D : 16'hFFFF);

    // R8 command during a frame is dropped
    cA = mkCmd(1'b0, 5'd3, 5'd4, 16'hBEEF);
    cB = mkCmd(1'b1, 5'd9, 5'd6, 16'h0000);
    divSel = 1'b0;
    armMonitor();
    wrReg(mdio_frame_pkg::REG_CMD, cA);
    repeat (500) @(negedge clk);
    wrReg(mdio_frame_pkg::REG_CMD, cB);
    rdReg(mdio_frame_pkg::REG_CMD, v);
    chk(v == cA, "R8 command kept mid-frame", v, cA);
    rdReg(mdio_frame_pkg::REG_STAT, v);
    chk(v[2] == 1'b0, "R8 still busy", 64'(v), 64'h0);
    waitIdle();
    chk(seenOut == expFrame(cA), "R8 frame intact", seenOut, expFrame(cA));
    rdReg(mdio_frame_pkg::REG_CMD, v);
    chk(v == cA, "R8 command after frame", v, cA);

    summary();
    $finish;
  end
endmodule